// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. It has a one-character holding buffer in front of a frame shifter. While the shifter sends one character, the host or a DMA engine can place the next character in the buffer. Two flags describe the buffer. The buffer-free flag says a new character may be written. The line-done flag says the shifter has sent its last bit and nothing is waiting behind it.

Bit timing comes from an external one-cycle `bit_tick` strobe, one pulse per bit time. Each frame has these parts, in order:

- a low start bit;
- eight data bits, least significant first;
- an optional address/data marker bit, whose value is programmable;
- one or two high stop bits.

Software takes the buffer in two steps. It first reads the status while the buffer-free flag is 1, then writes 0 to that flag. A DMA write loads the buffer and clears the flags in one step. Clearing `tx_en` returns the block to an idle line with both flags set.

Top module: `serial_tx_hold`

## Requirements
- R1: During and right after reset, `txd` is 1, `tx_empty` is 1 and `tx_end` is 1.
- R2: While `tx_en` is 0, `tx_empty` and `tx_end` read 1 from the next cycle on, and `txd` is 1. This holds even if a frame was in progress, and even if a status read and a write of 0 arrive while disabled.
- R3: A frame starts on a `bit_tick` with a 0 start bit. The eight data bits follow, bit 0 first, and each bit lasts from one `bit_tick` to the next.
- R4: When `mp_on` is 1 at frame load, one extra bit equal to `mp_val` follows the data bits. When `mp_on` is 0, no such bit is sent.
- R5: The frame ends with one stop bit of value 1, or two when `two_stop` is 1 at frame load. When no frame is in progress, `txd` stays 1.
- R6: On a `bit_tick` where `tx_empty` is 0 and the shifter is idle or on its last bit, the buffer moves into the shifter, and `tx_empty` is 1 from the next cycle.
- R7: If a character is buffered when the last bit of a frame ends, its start bit follows at once, with no idle bit time between the frames.
- R8: A pulse on `stat_wr` with `stat_wempty`=0 clears both `tx_empty` and `tx_end` only if `stat_rd` was pulsed while `tx_empty` was 1, with no clear since. A write without that read, or a write with `stat_wempty`=1, leaves both flags unchanged. A clear takes priority over a load in the same cycle.
- R9: A `dma_wr` pulse stores `wdata` in the buffer and clears `tx_empty` and `tx_end` in the next cycle. A `hold_wr` pulse stores `wdata` without touching the flags.
- R10: `tx_end` becomes 1 only when the last bit of a frame ends while `tx_empty` is 1. When a character is waiting at that moment, `tx_end` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| bit_tick | input | 1 | One-cycle strobe marking each bit time |
| stat_rd | input | 1 | Status read strobe (arms the clear) |
| stat_wr | input | 1 | Status write strobe |
| stat_wempty | input | 1 | Value written to the buffer-free flag |
| hold_wr | input | 1 | Host write of `wdata` into the buffer |
| dma_wr | input | 1 | DMA write of `wdata` into the buffer, clears the flags |
| wdata | input | 8 | Character data |
| mp_on | input | 1 | Append the marker bit |
| mp_val | input | 1 | Value of the marker bit |
| two_stop | input | 1 | Send two stop bits |
| txd | output | 1 | Serial line, idles at 1 |
| tx_empty | output | 1 | Buffer-free flag |
| tx_end | output | 1 | Line-done flag |

## Verification
The bench first sends single characters through the host read-then-clear path, with no marker bit and one stop bit. This shows the basic frame and the idle gaps between frames. It then sends DMA-fed characters back to back with the marker bit set to 1 and two stop bits; this separates the R7 chaining and the R10 rule for `tx_end` from the single-frame case. Further patterns cover a clear without a prior read, a write of 1, writes while disabled, and a disable in the middle of a frame. Each of these shows whether a flag moved when it should have stayed put. The behavioural queue model is compared with the line and both flags on every cycle, so a frame that is one bit too long or too short shows up as a cycle mismatch.

// File: rtl/sertx_pkg.sv
// Shared types for the buffered serial transmitter.
// Assumes frame options are sampled once, when a character is loaded.
package sertx_pkg;

    // Per-frame options, captured at load time.
    typedef struct packed {
        logic mp_on;     // append marker bit
        logic mp_val;    // marker bit value
        logic two_stop;  // second stop bit
    } frame_cfg_t;

    // Total bits in a frame: start + data + optional marker + stops.
    function automatic int unsigned frame_len(int unsigned data_w, frame_cfg_t c);
        return 32'd2 + data_w + {31'd0, c.mp_on} + {31'd0, c.two_stop};
    endfunction

endpackage

// File: rtl/sertx_holdflags.sv
// Holding buffer with the buffer-free and line-done flags.
// Assumes: load and end_evt come from the shifter and are qualified by tx_en;
// the software clear needs a status read while the buffer-free flag is 1.
module sertx_holdflags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic              stat_wempty,
    input  logic              hold_wr,
    input  logic              dma_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load,
    input  logic              end_evt,
    output logic [DATA_W-1:0] hold_q,
    output logic              empty_q,
    output logic              end_q
);

    logic armed_q;
    logic sw_clr;
    logic any_clr;

    // Clear events: armed write of 0, or a DMA load.
    always_comb begin
        sw_clr  = stat_wr && !stat_wempty && armed_q;
        any_clr = sw_clr || dma_wr;
    end

    // Holding buffer capture from host or DMA.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (hold_wr || dma_wr)
            hold_q <= wdata;
    end

    // Arm bit: remembers that the flag was read as 1.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en)
            armed_q <= 1'b0;
        else if (stat_rd && empty_q)
            armed_q <= 1'b1;
        else if (any_clr)
            armed_q <= 1'b0;
    end

    // Buffer-free flag: forced when disabled, clear beats load.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en)
            empty_q <= 1'b1;
        else if (any_clr)
            empty_q <= 1'b0;
        else if (load)
            empty_q <= 1'b1;
    end

    // Line-done flag: forced when disabled, set at a drained frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en)
            end_q <= 1'b1;
        else if (any_clr)
            end_q <= 1'b0;
        else if (end_evt)
            end_q <= 1'b1;
    end

endmodule

// File: rtl/sertx_shifter.sv
// Frame shifter: builds start/data/marker/stop bits and shifts them out,
// one bit per bit_tick. Assumes bit_tick is a one-cycle strobe.
// Loads only on a tick, so every bit, the start bit included, lasts a full bit time.
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              bit_tick,
    input  logic              buf_empty,
    input  logic [DATA_W-1:0] buf_data,
    input  frame_cfg_t        cfg,
    output logic              load,
    output logic              end_evt,
    output logic              txd
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] frame_q;
    logic [FRAME_W-1:0] frame_new;
    logic [CNT_W-1:0]   left_q;
    logic [CNT_W-1:0]   len_new;
    logic               busy_q;
    logic               on_last;

    // Frame image with the start bit at index 0, padded with ones.
    always_comb begin
        frame_new             = '1;
        frame_new[0]          = 1'b0;
        frame_new[DATA_W:1]   = buf_data;
        if (cfg.mp_on)
            frame_new[DATA_W+1] = cfg.mp_val;
        len_new = CNT_W'(frame_len(DATA_W, cfg));
    end

    // Load and end-of-frame decisions for this tick.
    always_comb begin
        on_last = busy_q && (left_q == CNT_W'(1));
        load    = tx_en && bit_tick && !buf_empty && (!busy_q || on_last);
        end_evt = tx_en && bit_tick && on_last && buf_empty;
    end

    // Shift state: load, shift or drop to idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            frame_q <= '1;
            left_q  <= '0;
            busy_q  <= 1'b0;
        end else if (load) begin
            frame_q <= frame_new;
            left_q  <= len_new;
            busy_q  <= 1'b1;
        end else if (busy_q && bit_tick) begin
            if (on_last) begin
                frame_q <= '1;
                left_q  <= '0;
                busy_q  <= 1'b0;
            end else begin
                frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
                left_q  <= left_q - CNT_W'(1);
            end
        end
    end

    // Line output: idle high.
    assign txd = busy_q ? frame_q[0] : 1'b1;

endmodule

// File: rtl/serial_tx_hold.sv
// Top of the buffered serial transmitter: holding buffer and flags in
// front of a frame shifter. Assumes all inputs are synchronous to clk.
module serial_tx_hold
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              bit_tick,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic              stat_wempty,
    input  logic              hold_wr,
    input  logic              dma_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mp_on,
    input  logic              mp_val,
    input  logic              two_stop,
    output logic              txd,
    output logic              tx_empty,
    output logic              tx_end
);

    logic [DATA_W-1:0] hold_data;
    logic              load;
    logic              end_evt;
    frame_cfg_t        cfg;

    // Gather frame options into one struct.
    always_comb begin
        cfg.mp_on    = mp_on;
        cfg.mp_val   = mp_val;
        cfg.two_stop = two_stop;
    end

    sertx_holdflags #(.DATA_W(DATA_W)) flags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .stat_rd    (stat_rd),
        .stat_wr    (stat_wr),
        .stat_wempty(stat_wempty),
        .hold_wr    (hold_wr),
        .dma_wr     (dma_wr),
        .wdata      (wdata),
        .load       (load),
        .end_evt    (end_evt),
        .hold_q     (hold_data),
        .empty_q    (tx_empty),
        .end_q      (tx_end)
    );

    sertx_shifter #(.DATA_W(DATA_W)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .bit_tick (bit_tick),
        .buf_empty(tx_empty),
        .buf_data (hold_data),
        .cfg      (cfg),
        .load     (load),
        .end_evt  (end_evt),
        .txd      (txd)
    );

endmodule

// File: rtl/serial_tx_hold_chk.sv
// Port-level property checker for serial_tx_hold, attached by bind.
module serial_tx_hold_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic bit_tick,
    input logic stat_wr,
    input logic stat_wempty,
    input logic dma_wr,
    input logic txd,
    input logic tx_empty,
    input logic tx_end
);

    AST_OFF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (tx_empty && tx_end));                                  // R2
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> txd);                                                   // R2
    AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> $past(bit_tick));                                   // R3
    AST_WR1_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_empty && stat_wr && stat_wempty && !dma_wr) |=> tx_empty); // R8
    AST_DMA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && dma_wr) |=> (!tx_empty && !tx_end));                     // R9
    AST_END_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_end) |-> ($past(!tx_en) || $past(bit_tick)));             // R10

endmodule

bind serial_tx_hold serial_tx_hold_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .bit_tick   (bit_tick),
    .stat_wr    (stat_wr),
    .stat_wempty(stat_wempty),
    .dma_wr     (dma_wr),
    .txd        (txd),
    .tx_empty   (tx_empty),
    .tx_end     (tx_end)
);

// File: tb/serial_tx_hold_tb_top.sv
// Bench: behavioural queue model of the line and flags, compared every cycle.
module serial_tx_hold_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       bit_tick = 1'b0;
    logic       stat_rd = 1'b0;
    logic       stat_wr = 1'b0;
    logic       stat_wempty = 1'b1;
    logic       hold_wr = 1'b0;
    logic       dma_wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       mp_on = 1'b0;
    logic       mp_val = 1'b0;
    logic       two_stop = 1'b0;
    logic       txd;
    logic       tx_empty;
    logic       tx_end;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  running  = 1'b0;
    bit  done     = 1'b0;

    // Model state
    bit       q[$];
    bit       m_empty = 1'b1;
    bit       m_end   = 1'b1;
    bit       m_arm   = 1'b0;
    bit [7:0] m_hold  = 8'h00;
    bit       clr, ld, ev;

    always #10 clk = ~clk;  // 50 MHz

    serial_tx_hold dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_tick(bit_tick),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wempty(stat_wempty),
        .hold_wr(hold_wr), .dma_wr(dma_wr), .wdata(wdata),
        .mp_on(mp_on), .mp_val(mp_val), .two_stop(two_stop),
        .txd(txd), .tx_empty(tx_empty), .tx_end(tx_end)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model, updated on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_empty = 1; m_end = 1; m_arm = 0; m_hold = 0;
        end else begin
            clr = (stat_wr && !stat_wempty && m_arm) || dma_wr;
            if (!tx_en) begin
                q.delete(); m_empty = 1; m_end = 1; m_arm = 0;
            end else begin
                ld = bit_tick && !m_empty && (q.size() <= 1);
                ev = bit_tick && (q.size() == 1) && m_empty;
                if (ld) begin
                    q.delete();
                    q.push_back(1'b0);
                    for (int i = 0; i < 8; i++) q.push_back(m_hold[i]);
                    if (mp_on) q.push_back(mp_val);
                    q.push_back(1'b1);
                    if (two_stop) q.push_back(1'b1);
                end else if (bit_tick && q.size() > 0) begin
                    void'(q.pop_front());
                end
                if (stat_rd && m_empty) m_arm = 1; else if (clr) m_arm = 0;
                if (clr) m_empty = 0; else if (ld) m_empty = 1;
                if (clr) m_end = 0; else if (ev) m_end = 1;
            end
            if (hold_wr || dma_wr) m_hold = wdata;
        end
    end

    // Every-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (running) begin
            // R3 R4 R5 R7: line bit by bit
            check(txd == ((q.size() > 0) ? q[0] : 1'b1), "R3", int'(txd),
                  int'((q.size() > 0) ? q[0] : 1'b1));
            check(tx_empty == m_empty, "R6", int'(tx_empty), int'(m_empty));
            check(tx_end == m_end, "R10", int'(tx_end), int'(m_end));
        end
    end

    // Bit-time strobe every fourth cycle.
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
        end
    end

    task automatic host_write(input logic [7:0] d);
        @(negedge clk); hold_wr = 1; wdata = d;
        @(negedge clk); hold_wr = 0;
    endtask

    task automatic host_clear(input bit do_read, input bit val);
        if (do_read) begin
            @(negedge clk); stat_rd = 1;
            @(negedge clk); stat_rd = 0;
        end else begin
            @(negedge clk);
        end
        stat_wr = 1; stat_wempty = val;
        @(negedge clk); stat_wr = 0; stat_wempty = 1;
    endtask

    task automatic dma_write(input logic [7:0] d);
        @(negedge clk); dma_wr = 1; wdata = d;
        @(negedge clk); dma_wr = 0;
    endtask

    task automatic wait_drained();
        while (!(tx_end && tx_empty)) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(txd == 1'b1, "R1", int'(txd), 1);
        check(tx_empty == 1'b1, "R1", int'(tx_empty), 1);
        check(tx_end == 1'b1, "R1", int'(tx_end), 1);
        rst_n = 1'b1;
        running = 1'b1;

        // R2: clear sequence ignored while disabled
        host_write(8'h3C);
        host_clear(1, 0);
        check(tx_empty == 1'b1, "R2", int'(tx_empty), 1);
        check(tx_end == 1'b1, "R2", int'(tx_end), 1);

        tx_en = 1'b1;
        // R8: read then write 0 clears both flags
        host_write(8'hA5);
        host_clear(1, 0);
        check(tx_empty == 1'b0, "R8", int'(tx_empty), 0);
        check(tx_end == 1'b0, "R8", int'(tx_end), 0);
        wait_drained();

        // R8: write 0 without a prior read has no effect
        host_write(8'h11);
        host_clear(0, 0);
        check(tx_empty == 1'b1, "R8", int'(tx_empty), 1);
        // R8: write 1 after a read has no effect
        host_clear(1, 1);
        check(tx_empty == 1'b1, "R8", int'(tx_empty), 1);
        check(tx_end == 1'b1, "R8", int'(tx_end), 1);
        host_clear(0, 0);  // now armed: clears and sends 0x11
        check(tx_empty == 1'b0, "R8", int'(tx_empty), 0);
        wait_drained();

        // R4 R5 R7 R9 R10: DMA-fed back-to-back, marker 1, two stops
        mp_on = 1; mp_val = 1; two_stop = 1;
        dma_write(8'h5A);
        check(tx_empty == 1'b0, "R9", int'(tx_empty), 0);
        check(tx_end == 1'b0, "R9", int'(tx_end), 0);
        while (!tx_empty) @(negedge clk);
        dma_write(8'h81);
        while (!tx_empty) @(negedge clk);
        dma_write(8'hC3);
        check(tx_end == 1'b0, "R10", int'(tx_end), 0);
        wait_drained();
        check(tx_end == 1'b1, "R10", int'(tx_end), 1);

        // R2: disable in the middle of a frame
        mp_val = 0;
        dma_write(8'hF0);
        repeat (14) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        check(txd == 1'b1, "R2", int'(txd), 1);
        check(tx_empty == 1'b1, "R2", int'(tx_empty), 1);
        check(tx_end == 1'b1, "R2", int'(tx_end), 1);
        tx_en = 1'b1;

        // R4 R5: plain frame, no marker, one stop
        mp_on = 0; two_stop = 0;
        dma_write(8'h0F);
        wait_drained();
        mp_on = 1; mp_val = 0; two_stop = 0;
        dma_write(8'h96);
        wait_drained();

        running = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule